// File: doc/BRIEF.md
# Output Voltage Fault Supervisor

This block decides when the regulated output of a multiphase step-down converter has failed badly enough that the power stage must be stopped. It samples the results of comparators that sit outside the block. One comparator reports that the output is below 60 % of the reference. Two others report an over-voltage: one trips at 115 % of the reference and the other at a fixed level. A mode input picks which of the two is used. The block also samples one overcurrent flag per phase. From these inputs it drives a latched fault pin, a command that turns every switch off, a crowbar command that forces every low-side switch on, and a per-phase current-limit command.

An under-voltage must be seen on several consecutive clock samples before it latches. Once latched it turns all switches off. An over-voltage latches on a single sample and engages the crowbar. The crowbar outranks the under-voltage response. Overcurrent never latches. It only makes the affected phase skip cycles while the flag is present. It becomes fatal only if the output then sags into under-voltage. A latched fault holds until the supply-good input or the output enable goes low, which clears all state on the next clock edge.

Top module: `vout_fault_supervisor`

## Requirements
- R1: During reset, and on the clock edge after either `supply_ok` or `out_en` is sampled low, the outputs are `fault_o`=0, `crowbar_o`=0, `all_off_o`=1 and `limit_o`=0, and the under-voltage count restarts from zero.
- R2: With the block enabled, `uv_flag` sampled high on UV_QUAL consecutive edges (default 2) latches an under-voltage trip at the last of those edges. From then on `fault_o`=1, `all_off_o`=1 and `crowbar_o`=0.
- R3: Fewer than UV_QUAL consecutive high samples of `uv_flag` never latch. A single low sample discards the samples already counted.
- R4: With the block enabled, the selected over-voltage flag sampled high on one edge latches an over-voltage trip at that edge. From then on `fault_o`=1, `crowbar_o`=1 and `all_off_o`=0.
- R5: With `ovp_fixed_sel`=0 the block reacts only to `ov_ratio`, and with `ovp_fixed_sel`=1 only to `ov_fixed`. The unselected flag has no effect.
- R6: Over-voltage has priority. It wins when both trips qualify on the same edge, and it replaces an under-voltage trip already latched. An under-voltage never replaces a latched over-voltage trip.
- R7: A latched trip holds whatever the comparator flags do until `supply_ok` or `out_en` is sampled low. One low sample of either is enough to clear it.
- R8: While enabled with no trip latched, `limit_o[i]` equals `oc_flag[i]` sampled on the previous edge. Overcurrent never sets `fault_o`. `limit_o` is all zero while a trip is latched or the block is disabled.
- R9: Overcurrent followed by a qualified under-voltage latches the under-voltage trip, as in R2.
- R10: `crowbar_o` and `all_off_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Control supply above its turn-on level |
| out_en | input | 1 | Output enable; low clears all latched state |
| uv_flag | input | 1 | Output below 60 % of reference |
| ov_ratio | input | 1 | Output above 115 % of reference |
| ov_fixed | input | 1 | Output above the fixed over-voltage level |
| ovp_fixed_sel | input | 1 | 1 selects `ov_fixed`, 0 selects `ov_ratio` |
| oc_flag | input | NUM_PHASES | Per-phase overcurrent flags |
| fault_o | output | 1 | Latched fault pin |
| all_off_o | output | 1 | Turn every switch off |
| crowbar_o | output | 1 | Force every low-side switch on |
| limit_o | output | NUM_PHASES | Per-phase cycle-skip (current limit) command |

## Verification
The hardest case to reach from the ports is a priority change inside a latched state. This is an over-voltage arriving after an under-voltage trip has already latched, or the reverse. It needs a qualified under-voltage run first, then the other flag, and no disable in between. The bench builds these sequences on exact clock edges. It also places the one-sample gap that must restart the under-voltage count. It covers the edge where both trips qualify together.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        TRIP_NONE = 2'd0,
        TRIP_UV   = 2'd1,
        TRIP_OV   = 2'd2
    } trip_e;

endpackage

// File: rtl/fsup_ov_select.sv
module fsup_ov_select (
    input  logic fixed_sel,
    input  logic ov_ratio,
    input  logic ov_fixed,
    input  logic enable,
    output logic ov_hit
);

    logic picked;

    always_comb begin
        picked = fixed_sel ? ov_fixed : ov_ratio;
        ov_hit = enable && picked;
    end

endmodule

// File: rtl/fsup_uv_qualifier.sv
module fsup_uv_qualifier #(
    parameter int UV_QUAL = 2,
    localparam int CNT_W  = $clog2(UV_QUAL + 1)
) (
    input  logic             uv_flag,
    input  logic             armed,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             uv_trip
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(UV_QUAL - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(UV_QUAL);

    always_comb begin
        cnt_d   = '0;
        uv_trip = 1'b0;
        if (armed && uv_flag) begin
            cnt_d   = (cnt_q >= TOP) ? TOP : cnt_q + 1'b1;
            uv_trip = (cnt_q >= LAST);
        end
    end

endmodule

// File: rtl/fsup_phase_limit.sv
module fsup_phase_limit #(
    parameter int NUM_PHASES = 3
) (
    input  logic [NUM_PHASES-1:0] oc_flag,
    input  logic                  running,
    output logic [NUM_PHASES-1:0] limit_d
);

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        always_comb begin
            limit_d[p] = running && oc_flag[p];
        end
    end

endmodule

// File: rtl/vout_fault_supervisor.sv
module vout_fault_supervisor
    import fsup_pkg::*;
#(
    parameter int NUM_PHASES = 3,
    parameter int UV_QUAL    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_ok,
    input  logic                  out_en,
    input  logic                  uv_flag,
    input  logic                  ov_ratio,
    input  logic                  ov_fixed,
    input  logic                  ovp_fixed_sel,
    input  logic [NUM_PHASES-1:0] oc_flag,
    output logic                  fault_o,
    output logic                  all_off_o,
    output logic                  crowbar_o,
    output logic [NUM_PHASES-1:0] limit_o
);

    localparam int CNT_W = $clog2(UV_QUAL + 1);

    typedef struct packed {
        trip_e                 trip;
        logic [CNT_W-1:0]      uv_cnt;
        logic                  fault;
        logic                  all_off;
        logic                  crowbar;
        logic [NUM_PHASES-1:0] limit;
    } sup_state_t;

    sup_state_t st_d, st_q;

    logic                  enable;
    logic                  ov_hit;
    logic                  uv_trip;
    logic                  uv_armed;
    logic [CNT_W-1:0]      uv_cnt_d;
    logic                  running_d;
    logic [NUM_PHASES-1:0] limit_d;
    trip_e                 trip_d;

    always_comb begin
        enable   = supply_ok && out_en;
        uv_armed = enable && (st_q.trip == TRIP_NONE);
    end

    fsup_ov_select u_ov_select (
        .fixed_sel (ovp_fixed_sel),
        .ov_ratio  (ov_ratio),
        .ov_fixed  (ov_fixed),
        .enable    (enable),
        .ov_hit    (ov_hit)
    );

    fsup_uv_qualifier #(
        .UV_QUAL (UV_QUAL)
    ) u_uv_qual (
        .uv_flag (uv_flag),
        .armed   (uv_armed),
        .cnt_q   (st_q.uv_cnt),
        .cnt_d   (uv_cnt_d),
        .uv_trip (uv_trip)
    );

    // Next trip state: over-voltage outranks under-voltage in every state.
    always_comb begin
        trip_d = st_q.trip;
        if (!enable) begin
            trip_d = TRIP_NONE;
        end else begin
            unique case (st_q.trip)
                TRIP_NONE: begin
                    if (ov_hit)       trip_d = TRIP_OV;
                    else if (uv_trip) trip_d = TRIP_UV;
                end
                TRIP_UV: begin
                    if (ov_hit)       trip_d = TRIP_OV;
                end
                TRIP_OV: begin
                    trip_d = TRIP_OV;
                end
                default: trip_d = TRIP_NONE;
            endcase
        end
        running_d = enable && (trip_d == TRIP_NONE);
    end

    fsup_phase_limit #(
        .NUM_PHASES (NUM_PHASES)
    ) u_phase_limit (
        .oc_flag (oc_flag),
        .running (running_d),
        .limit_d (limit_d)
    );

    always_comb begin
        st_d         = st_q;
        st_d.trip    = trip_d;
        st_d.uv_cnt  = (trip_d == TRIP_NONE) ? uv_cnt_d : '0;
        st_d.fault   = (trip_d != TRIP_NONE);
        st_d.crowbar = (trip_d == TRIP_OV);
        st_d.all_off = !enable || (trip_d == TRIP_UV);
        st_d.limit   = limit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.trip    <= TRIP_NONE;
            st_q.uv_cnt  <= '0;
            st_q.fault   <= 1'b0;
            st_q.all_off <= 1'b1;
            st_q.crowbar <= 1'b0;
            st_q.limit   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        fault_o   = st_q.fault;
        all_off_o = st_q.all_off;
        crowbar_o = st_q.crowbar;
        limit_o   = st_q.limit;
    end

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
    parameter int NUM_PHASES = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  supply_ok,
    input logic                  out_en,
    input logic                  uv_flag,
    input logic                  ov_ratio,
    input logic                  ov_fixed,
    input logic                  ovp_fixed_sel,
    input logic                  fault_o,
    input logic                  all_off_o,
    input logic                  crowbar_o,
    input logic [NUM_PHASES-1:0] limit_o
);

    // R1: a disable sample clears every latch on the next edge
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_ok && out_en) |=> (!fault_o && !crowbar_o && all_off_o && limit_o == '0));

    // R3: a low under-voltage sample with no trip latched never turns switches off
    a_r3_no_trip_on_clear_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && out_en && !fault_o && !uv_flag) |=> !all_off_o);

    // R4: the selected over-voltage flag engages the crowbar on the next edge
    a_r4_ov_crowbar: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && out_en && (ovp_fixed_sel ? ov_fixed : ov_ratio)) |=> (crowbar_o && fault_o));

    // R7: a latched fault holds while enabled
    a_r7_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && supply_ok && out_en) |=> fault_o);

    // R6: a latched crowbar is never replaced while enabled
    a_r6_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crowbar_o && supply_ok && out_en) |=> crowbar_o);

    // R8: no current limiting while a fault is latched
    a_r8_limit_idle_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (limit_o == '0));

    // R10: crowbar and all-off are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(crowbar_o && all_off_o));

endmodule

bind vout_fault_supervisor fsup_checker #(.NUM_PHASES(NUM_PHASES)) u_fsup_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .out_en        (out_en),
    .uv_flag       (uv_flag),
    .ov_ratio      (ov_ratio),
    .ov_fixed      (ov_fixed),
    .ovp_fixed_sel (ovp_fixed_sel),
    .fault_o       (fault_o),
    .all_off_o     (all_off_o),
    .crowbar_o     (crowbar_o),
    .limit_o       (limit_o)
);

// File: tb/test_vout_fault_supervisor.sv
module test_vout_fault_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          out_en = 1'b0;
    logic          uv_flag = 1'b0;
    logic          ov_ratio = 1'b0;
    logic          ov_fixed = 1'b0;
    logic          ovp_fixed_sel = 1'b0;
    logic [NP-1:0] oc_flag = '0;
    logic          fault_o, all_off_o, crowbar_o;
    logic [NP-1:0] limit_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vout_fault_supervisor #(.NUM_PHASES(NP), .UV_QUAL(2)) i_vout_fault_supervisor (
        .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .out_en (out_en),
        .uv_flag (uv_flag), .ov_ratio (ov_ratio), .ov_fixed (ov_fixed),
        .ovp_fixed_sel (ovp_fixed_sel), .oc_flag (oc_flag),
        .fault_o (fault_o), .all_off_o (all_off_o), .crowbar_o (crowbar_o),
        .limit_o (limit_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic ef, logic ec, logic eo, logic [NP-1:0] el);
        n_tests++;
        if (fault_o !== ef || crowbar_o !== ec || all_off_o !== eo || limit_o !== el) begin
            n_fail++;
            $display("FAIL %s: fault/crowbar/off/limit = %b/%b/%b/%b expected %b/%b/%b/%b",
                     req, fault_o, crowbar_o, all_off_o, limit_o, ef, ec, eo, el);
        end
    endtask

    task automatic quiet();
        uv_flag = 0; ov_ratio = 0; ov_fixed = 0; oc_flag = '0;
    endtask

    task automatic rearm();
        quiet();
        out_en = 0; tick();
        out_en = 1; tick();
    endtask

    task automatic t_reset();
        chk("R1 reset", 0, 0, 1, '0);
        rst_n = 1; supply_ok = 1; out_en = 1; tick();
        chk("R1 enabled idle", 0, 0, 0, '0);
    endtask

    task automatic t_uv_qualify();
        rearm();
        uv_flag = 1; tick();
        chk("R3 one uv sample", 0, 0, 0, '0);
        uv_flag = 0; tick();
        uv_flag = 1; tick();
        chk("R3 count restarted", 0, 0, 0, '0);
        tick();
        chk("R2 uv latched", 1, 0, 1, '0);
        uv_flag = 0; tick(); tick();
        chk("R7 uv holds", 1, 0, 1, '0);
    endtask

    task automatic t_ov_modes();
        rearm();
        ovp_fixed_sel = 0; ov_fixed = 1; tick();
        chk("R5 fixed ignored in ratio mode", 0, 0, 0, '0);
        ov_fixed = 0; ov_ratio = 1; tick();
        chk("R4 ratio ov crowbar", 1, 1, 0, '0);
        rearm();
        ovp_fixed_sel = 1; ov_ratio = 1; tick();
        chk("R5 ratio ignored in fixed mode", 0, 0, 0, '0);
        ov_ratio = 0; ov_fixed = 1; tick();
        chk("R4 fixed ov crowbar", 1, 1, 0, '0);
        ovp_fixed_sel = 0; quiet();
    endtask

    task automatic t_priority();
        rearm();
        uv_flag = 1; tick();
        ov_ratio = 1; tick();
        chk("R6 same-edge ov wins", 1, 1, 0, '0);
        rearm();
        uv_flag = 1; tick(); tick();
        chk("R6 uv first", 1, 0, 1, '0);
        ov_ratio = 1; tick();
        chk("R6 ov replaces uv", 1, 1, 0, '0);
        rearm();
        ov_ratio = 1; tick();
        ov_ratio = 0; uv_flag = 1; tick(); tick(); tick();
        chk("R6 uv cannot replace ov", 1, 1, 0, '0);
    endtask

    task automatic t_clear();
        rearm();
        ov_ratio = 1; tick();
        supply_ok = 0; tick();
        chk("R1 supply low clears", 0, 0, 1, '0);
        supply_ok = 1; ov_ratio = 0; tick();
        chk("R7 re-enabled clean", 0, 0, 0, '0);
        uv_flag = 1; out_en = 0; tick();
        out_en = 1; tick();
        chk("R1 disable restarts uv count", 0, 0, 0, '0);
        quiet(); tick();
    endtask

    task automatic t_overcurrent();
        rearm();
        oc_flag = 3'b101; tick();
        chk("R8 limit follows oc", 0, 0, 0, 3'b101);
        oc_flag = 3'b010; tick();
        chk("R8 limit tracks", 0, 0, 0, 3'b010);
        oc_flag = '0; tick();
        chk("R8 oc released no latch", 0, 0, 0, '0);
        oc_flag = 3'b111; uv_flag = 1; tick();
        chk("R9 oc with first uv", 0, 0, 0, 3'b111);
        tick();
        chk("R9 uv fatal after oc", 1, 0, 1, '0);
        out_en = 0; tick();
        chk("R8 limit idle when disabled", 0, 0, 1, '0);
        quiet(); out_en = 1; tick();
    endtask

    initial begin
        #(CLK_PERIOD*2 + 1);
        t_reset();
        t_uv_qualify();
        t_ov_modes();
        t_priority();
        t_clear();
        t_overcurrent();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule